// File: doc/BRIEF.md
# Machine-Cycle Timer / Event Counter

This block is a 16-bit up-counter paced by a machine-cycle strobe. The strobe fires once every six oscillator clocks. In timer function the count advances on every strobe, so it counts at one sixth of the clock rate. In event-counter function the block samples an external input once per machine cycle. It counts one event for each high sample that is followed by a low sample. The new value appears one machine cycle after the strobe that saw the falling transition. Because of this, the external input can be counted at most once every twelve oscillator clocks.

The rest of the chip can preload the count through a parallel load port. A rollover from the all-ones value sets a sticky overflow flag, which stays set until the clear input removes it. When run enable is low the count holds its value. The input keeps being sampled while the count is stopped, so restarting never counts an edge from stale samples.

Top module: `mct_timer_counter`

## Requirements
- R1: During and after a synchronous reset (`rst` high at a clock edge), `count` reads 0, `ovf` reads 0, and the machine-cycle phase restarts. The first strobe falls on the sixth clock edge with `rst` low.
- R2: With `cnt_sel` = 0 (timer function) and `run_en` = 1, `count` increases by exactly one on every sixth clock edge, and it changes on no other edge unless a load occurs.
- R3: With `cnt_sel` = 1 (event-counter function), `ext_in` is sampled only on machine-cycle strobe edges. An event is recognised only when one sample is 1 and the next sample is 0.
- R4: In event-counter function, the increment for an event is applied on the strobe edge after the one that sampled the low level, which is six clocks later.
- R5: While `run_en` = 0, `count` holds its value. Samples are still taken during this time, so a level that stays low across the restart produces no count.
- R6: `load_en` = 1 writes `load_val` into `count` on that edge, even if an increment is due on the same edge. It also sets the held sample to the current `ext_in` level and discards any pending event.
- R7: An increment from 16'hFFFF gives 16'h0000 and sets `ovf`. `ovf` stays 1 until an edge where `ovf_clr` = 1 and no new rollover occurs. If both happen on the same edge, the flag stays set.
- R8: In event-counter function no increment happens without a recognised event, however many strobes pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | 1 lets the count advance |
| cnt_sel | input | 1 | 0 selects timer function, 1 selects event-counter function |
| ext_in | input | 1 | External event input |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | 16 | Value written by a load |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Current count |
| ovf | output | 1 | Sticky rollover flag |

## Verification
The assertions assume that `ext_in` is a synchronous input that changes only between clock edges. They also assume that `ovf_clr` and `load_en` are ordinary single-cycle controls. The event-counter checks additionally assume that each `ext_in` level lasts at least one full machine cycle. The random stimulus respects this by holding `ext_in` for six to eighteen clocks at a time. Only the directed cases place a transition close to a strobe edge, and they do so at a known phase.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic {
        FN_TIMER   = 1'b0,
        FN_COUNTER = 1'b1
    } mct_fn_e;

    typedef struct packed {
        logic samp;   // level seen at the last strobe
        logic fall;   // high-then-low seen at the last strobe
    } mct_edge_t;

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
    parameter int MC_CLKS = 6
) (
    input  logic clk,
    input  logic rst,
    output logic mc_stb
);
    localparam int PW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        mc_stb  = (phase_q == LAST);
        phase_d = mc_stb ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

endmodule

// File: rtl/mct_fall_detect.sv
module mct_fall_detect
    import mct_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mc_stb,
    input  logic ext_in,
    input  logic load_en,
    output logic fall_seen
);
    mct_edge_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (load_en) begin
            e_d.samp = ext_in;
            e_d.fall = 1'b0;
        end else if (mc_stb) begin
            e_d.fall = e_q.samp & ~ext_in;
            e_d.samp = ext_in;
        end
        fall_seen = e_q.fall;
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    assert_fall_detect_R3: assert property (@(posedge clk) disable iff (rst)
        (mc_stb && !load_en && e_q.samp && !ext_in) |=> fall_seen);

    assert_no_sample_between_R3: assert property (@(posedge clk) disable iff (rst)
        (!mc_stb && !load_en) |=> $stable(e_q));

endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_req,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } core_t;

    core_t c_d, c_q;
    logic  wrap;

    always_comb begin
        c_d  = c_q;
        wrap = 1'b0;
        if (load_en) begin
            c_d.cnt = load_val;
        end else if (inc_req) begin
            c_d.cnt = c_q.cnt + 1'b1;
            wrap    = &c_q.cnt;
        end
        if (wrap)         c_d.ovf = 1'b1;
        else if (ovf_clr) c_d.ovf = 1'b0;
        count = c_q.cnt;
        ovf   = c_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!inc_req && !load_en) |=> $stable(count));

endmodule

// File: rtl/mct_timer_counter.sv
module mct_timer_counter
    import mct_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MC_CLKS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             cnt_sel,
    input  logic             ext_in,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic mc_stb;
    logic fall_seen;
    logic inc_req;

    mct_prescaler #(.MC_CLKS(MC_CLKS)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .mc_stb (mc_stb)
    );

    mct_fall_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .mc_stb    (mc_stb),
        .ext_in    (ext_in),
        .load_en   (load_en),
        .fall_seen (fall_seen)
    );

    always_comb begin
        inc_req = 1'b0;
        if (mc_stb && run_en)
            inc_req = (mct_fn_e'(cnt_sel) == FN_COUNTER) ? fall_seen : 1'b1;
    end

    mct_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .inc_req  (inc_req),
        .load_en  (load_en),
        .load_val (load_val),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf      (ovf)
    );

    assert_strobe_paced_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !mc_stb) |=> $stable(count));

    assert_event_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_sel && !fall_seen && !load_en) |=> $stable(count));

endmodule

// File: tb/sim_mct_timer_counter.sv
module sim_mct_timer_counter;
    logic        clk = 1'b0;
    logic        rst, run_en, cnt_sel, ext_in, load_en, ovf_clr;
    logic [15:0] load_val;
    logic [15:0] count;
    logic        ovf;

    int vecs  = 0;
    int fails = 0;

    // reference state
    int          m_ph;
    logic [15:0] m_cnt;
    logic        m_ovf, m_samp, m_fall;

    always #4 clk = ~clk;

    mct_timer_counter u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .cnt_sel(cnt_sel),
        .ext_in(ext_in), .load_en(load_en), .load_val(load_val),
        .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
    );

    function automatic logic exp_inc(input logic stb);
        if (!stb || !run_en) return 1'b0;
        return cnt_sel ? m_fall : 1'b1;
    endfunction

    task automatic model_edge();
        logic stb, inc, wrap;
        if (rst) begin
            m_ph = 0; m_cnt = '0; m_ovf = 0; m_samp = 0; m_fall = 0;
            return;
        end
        stb  = (m_ph == 5);
        inc  = exp_inc(stb);
        wrap = 1'b0;
        m_ph = stb ? 0 : m_ph + 1;
        if (load_en) begin
            m_cnt = load_val; m_samp = ext_in; m_fall = 0;
        end else begin
            if (inc) begin wrap = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
            if (stb) begin m_fall = m_samp & ~ext_in; m_samp = ext_in; end
        end
        if (wrap) m_ovf = 1'b1;
        else if (ovf_clr) m_ovf = 1'b0;
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check16({tag, " count"}, count, m_cnt);
        check16({tag, " ovf"}, {15'd0, ovf}, {15'd0, m_ovf});
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset();
        rst = 1; run_en = 0; cnt_sel = 0; ext_in = 0; load_en = 0;
        ovf_clr = 0; load_val = '0;
        steps(2, "R1");
        rst = 0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd7123));
        @(negedge clk);
        do_reset();
        check16("R1 reset count", count, 16'h0000);
        check16("R1 reset ovf", {15'd0, ovf}, 16'h0000);

        // R2: timer pace, 600 clocks -> 100 counts
        run_en = 1; cnt_sel = 0;
        steps(600, "R2");
        check16("R2 timer rate", count, 16'd100);

        // R4: event timing from a fresh phase
        do_reset();
        run_en = 1; cnt_sel = 1; ext_in = 1;
        steps(6, "R3");
        ext_in = 0;
        steps(6, "R3");
        steps(5, "R4");
        check16("R4 before apply", count, 16'd0);
        step("R4");
        check16("R4 after apply", count, 16'd1);

        // R8: steady low, no further counts
        steps(60, "R8");
        check16("R8 no event no count", count, 16'd1);

        // R5: stopped, input toggles, restart with low level
        run_en = 0;
        ext_in = 1; steps(12, "R5");
        ext_in = 0; steps(12, "R5");
        check16("R5 hold while stopped", count, 16'd1);
        run_en = 1; steps(24, "R5");
        check16("R5 no stale count", count, 16'd1);

        // R6: load over a running timer
        cnt_sel = 0; load_en = 1; load_val = 16'h1234;
        step("R6");
        check16("R6 load value", count, 16'h1234);
        load_en = 0;

        // R7: rollover and clear
        load_en = 1; load_val = 16'hFFFF; step("R7"); load_en = 0;
        steps(6, "R7");
        check16("R7 wrap count", count, 16'h0000);
        check16("R7 wrap flag", {15'd0, ovf}, 16'd1);
        steps(6, "R7");
        check16("R7 sticky", {15'd0, ovf}, 16'd1);
        ovf_clr = 1; step("R7"); ovf_clr = 0;
        check16("R7 cleared", {15'd0, ovf}, 16'd0);

        // R6: load makes a pending event vanish
        cnt_sel = 1; ext_in = 1; steps(12, "R6");
        ext_in = 0;
        held = count;
        load_en = 1; load_val = 16'h0042; step("R6"); load_en = 0;
        steps(24, "R6");
        check16("R6 load clears sample", count, 16'h0042);
        held = count;

        // random mix: levels held >= one machine cycle
        for (int seg = 0; seg < 400; seg++) begin
            int len;
            len     = 6 + int'($urandom_range(12));
            ext_in  = $urandom_range(1);
            run_en  = ($urandom_range(7) != 0);
            if ($urandom_range(15) == 0) cnt_sel = ~cnt_sel;
            for (int k = 0; k < len; k++) begin
                load_en  = ($urandom_range(39) == 0);
                load_val = ($urandom_range(3) == 0) ? 16'hFFF8 | 16'($urandom_range(7))
                                                    : 16'($urandom);
                ovf_clr  = ($urandom_range(29) == 0);
                step(cnt_sel ? "R3 random" : "R2 random");
            end
            load_en = 0; ovf_clr = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule